// File: doc/BRIEF.md
# Pipelined Instruction Fetch Stage

This block is the front end of a five-stage pipelined processor. It keeps a 32-bit program counter and reads a small word-organised instruction store at the address the counter gives. Each cycle it passes the fetched word and the address of the following word to the fetch-to-decode pipeline register. The counter steps by one word per cycle. When a later pipeline stage signals a taken branch, the counter instead loads the branch target that stage supplies.

The instruction store has 128 words of 32 bits. Only the seven low bits of the program counter index it, so any higher counter bits are ignored by the lookup but are still carried in the next-address field. A write port fills the store while reset is held, so a program can be placed in it without any external file. The port also works after reset.

Reset is synchronous and active high. It clears the counter and both pipeline register fields to zero, and it overrides the branch select.

Top module: `fetch_stage`

## Requirements
- R1: While `rst` is 1 at a rising edge, after that edge `ifid_instr` and `ifid_npc` are both 0 and the program counter is 0. This holds whatever `pc_sel` and `br_target` are.
- R2: On the first rising edge after reset is released, `ifid_instr` becomes word 0 of the store and `ifid_npc` becomes 1.
- R3: At a rising edge with `rst`=0 and `pc_sel`=0, the counter becomes PC+1. The pipeline register captures the store word at PC and the value PC+1, so consecutive edges fetch consecutive words.
- R4: At a rising edge with `rst`=0 and `pc_sel`=1, the counter loads `br_target`. The next edge then captures the word at the target and target+1.
- R5: Only PC bits [6:0] select the word. A PC of 0x85 fetches word 5, and `ifid_npc` then reads the full 32-bit value 0x86.
- R6: The incrementer wraps modulo 2^32. PC 0xFFFFFFFF fetches word 127 and gives `ifid_npc` = 0. The following fetch is word 0, and PC 127 followed by PC 128 fetches word 127 and then word 0.
- R7: At a rising edge with `ld_we`=1, word `ld_addr` takes `ld_data`. The pipeline register captures the value that was stored before that edge. With `ld_we`=0 the store is unchanged whatever `ld_addr` and `ld_data` hold.
- R8: A `pc_sel`=1 request during reset has no effect: the first fetch after release is still word 0 with `ifid_npc` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Store write enable |
| ld_addr | input | 7 | Store word index to write |
| ld_data | input | 32 | Word to write |
| pc_sel | input | 1 | 1 selects the branch target as next PC, 0 the incremented PC |
| br_target | input | 32 | Branch target from a later stage |
| ifid_instr | output | 32 | Pipeline register: fetched instruction |
| ifid_npc | output | 32 | Pipeline register: address of the following word |

## Verification
Four things are checked on every cycle by the assertions. Reset clears the counter and the outputs. The next-address field always equals the previous counter plus one. The counter either steps by one or takes the previous branch target, depending on the select. None of these properties looks at the instruction store. So whether the right word comes out, including the truncated index, the wrap cases and the ordering of a write against a read in the same cycle, can only be shown by the bench scenarios, which compare the output words against a reference model of the store.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
    parameter int XLEN       = 32;
    parameter int IMEM_WORDS = 128;
    localparam int IDX_W     = $clog2(IMEM_WORDS);

    typedef logic [XLEN-1:0]  word_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        word_t instr;
        word_t npc;
    } ifid_t;

    function automatic idx_t word_index(input word_t pc);
        return pc[IDX_W-1:0];
    endfunction
endpackage

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
    import fetch_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pc_sel,
    input  word_t br_target,
    output word_t pc_q,
    output word_t pc_inc
);
    word_t pc_next;

    assign pc_inc  = pc_q + word_t'(1);
    assign pc_next = pc_sel ? br_target : pc_inc;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end
endmodule

// File: rtl/fetch_imem.sv
module fetch_imem
    import fetch_pkg::*;
(
    input  logic  clk,
    input  logic  we,
    input  idx_t  waddr,
    input  word_t wdata,
    input  idx_t  raddr,
    output word_t rdata
);
    word_t store [IMEM_WORDS];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/fetch_ifid_reg.sv
module fetch_ifid_reg
    import fetch_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ifid_t d,
    output ifid_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/fetch_stage.sv
module fetch_stage
    import fetch_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ld_we,
    input  logic [IDX_W-1:0]     ld_addr,
    input  logic [XLEN-1:0]      ld_data,
    input  logic                 pc_sel,
    input  logic [XLEN-1:0]      br_target,
    output logic [XLEN-1:0]      ifid_instr,
    output logic [XLEN-1:0]      ifid_npc
);
    word_t pc_q;
    word_t pc_inc;
    word_t fetched;
    ifid_t stage_d;
    ifid_t stage_q;

    fetch_pc_unit u_pc (
        .clk       (clk),
        .rst       (rst),
        .pc_sel    (pc_sel),
        .br_target (br_target),
        .pc_q      (pc_q),
        .pc_inc    (pc_inc)
    );

    fetch_imem u_imem (
        .clk   (clk),
        .we    (ld_we),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (word_index(pc_q)),
        .rdata (fetched)
    );

    assign stage_d.instr = fetched;
    assign stage_d.npc   = pc_inc;

    fetch_ifid_reg u_ifid (
        .clk (clk),
        .rst (rst),
        .d   (stage_d),
        .q   (stage_q)
    );

    assign ifid_instr = stage_q.instr;
    assign ifid_npc   = stage_q.npc;
endmodule

// File: rtl/fetch_stage_chk.sv
module fetch_stage_chk
    import fetch_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  pc_sel,
    input word_t br_target,
    input word_t pc_q,
    input word_t ifid_instr,
    input word_t ifid_npc
);
    AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ifid_instr == '0 && ifid_npc == '0 && pc_q == '0)); // R1

    AST_NPC_TRACK: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ifid_npc == $past(pc_q) + word_t'(1))); // R3

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        !pc_sel |=> (pc_q == $past(pc_q) + word_t'(1))); // R3

    AST_BRANCH_LOAD: assert property (@(posedge clk) disable iff (rst)
        pc_sel |=> (pc_q == $past(br_target))); // R4
endmodule

bind fetch_stage fetch_stage_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .pc_sel     (pc_sel),
    .br_target  (br_target),
    .pc_q       (pc_q),
    .ifid_instr (ifid_instr),
    .ifid_npc   (ifid_npc)
);

// File: tb/fetch_stage_bench.sv
module fetch_stage_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_we = 1'b0;
    logic [6:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic        pc_sel = 1'b0;
    logic [31:0] br_target = '0;
    logic [31:0] ifid_instr;
    logic [31:0] ifid_npc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] mmem [WORDS];
    logic [31:0] mpc;
    logic [31:0] exp_instr;
    logic [31:0] exp_npc;

    fetch_stage u_fetch_stage (
        .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .pc_sel(pc_sel), .br_target(br_target), .ifid_instr(ifid_instr), .ifid_npc(ifid_npc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] model_next_pc(input logic r, input logic s,
                                                  input logic [31:0] t, input logic [31:0] pc);
        if (r) return 32'd0;
        return s ? t : pc + 32'd1;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input logic r, input logic s, input logic [31:0] t,
                        input logic we, input logic [6:0] a, input logic [31:0] d, input string tag);
        rst = r; pc_sel = s; br_target = t; ld_we = we; ld_addr = a; ld_data = d;
        @(posedge clk);
        exp_instr = r ? 32'd0 : mmem[mpc[6:0]];
        exp_npc   = r ? 32'd0 : mpc + 32'd1;
        if (we) mmem[a] = d;
        mpc = model_next_pc(r, s, t, mpc);
        @(negedge clk);
        check(ifid_instr, exp_instr, tag, "ifid_instr");
        check(ifid_npc,   exp_npc,   tag, "ifid_npc");
    endtask

    task automatic run(input logic s, input logic [31:0] t, input string tag);
        step(1'b0, s, t, 1'b0, 7'd0, 32'd0, tag);
    endtask

    initial begin
        process::self().srandom(32'd20240611);
        @(negedge clk);
        // R1 / R8: reset with a branch request, outputs stay zero
        step(1'b1, 1'b1, 32'h0000_0040, 1'b0, 7'd0, 32'd0, "R1");
        step(1'b1, 1'b1, 32'h1234_5678, 1'b0, 7'd0, 32'd0, "R8");
        // R7: fill the store while reset is held
        for (int i = 0; i < WORDS; i++)
            step(1'b1, 1'b0, 32'd0, 1'b1, 7'(i), $urandom(), "R7");
        step(1'b1, 1'b1, 32'h0000_0033, 1'b0, 7'd0, 32'd0, "R8");
        // R2 / R8: first fetch after release
        run(1'b0, 32'd0, "R2");
        for (int i = 0; i < 4; i++) run(1'b0, 32'd0, "R3");
        // R4: branch then fetch from target
        run(1'b1, 32'd5, "R4");
        run(1'b0, 32'd0, "R4");
        run(1'b0, 32'd0, "R3");
        // R5: high PC bits do not index
        run(1'b1, 32'h0000_0085, "R5");
        run(1'b0, 32'd0, "R5");
        run(1'b0, 32'd0, "R5");
        // R6: crossing word 127 -> 128
        run(1'b1, 32'd126, "R6");
        for (int i = 0; i < 3; i++) run(1'b0, 32'd0, "R6");
        // R6: 32-bit wrap
        run(1'b1, 32'hFFFF_FFFF, "R6");
        run(1'b0, 32'd0, "R6");
        run(1'b0, 32'd0, "R6");
        // R7: disabled write leaves word 10, enabled write changes word 11
        step(1'b0, 1'b0, 32'd0, 1'b0, 7'd10, 32'hDEAD_BEEF, "R7");
        step(1'b0, 1'b0, 32'd0, 1'b1, 7'd11, 32'hCAFE_F00D, "R7");
        run(1'b1, 32'd10, "R7");
        run(1'b0, 32'd0, "R7");
        run(1'b0, 32'd0, "R7");
        run(1'b0, 32'd0, "R7");
        // R7: write to the word being fetched in the same edge
        run(1'b1, 32'd20, "R7");
        step(1'b0, 1'b0, 32'd0, 1'b1, 7'd20, 32'h0BAD_F00D, "R7");
        run(1'b1, 32'd20, "R7");
        run(1'b0, 32'd0, "R7");
        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            logic r, s, we;
            r  = ($urandom_range(0, 39) == 0);
            s  = ($urandom_range(0, 7) == 0);
            we = ($urandom_range(0, 5) == 0);
            step(r, s, $urandom(), we, 7'($urandom()), $urandom(), r ? "R1" : (s ? "R4" : "R3"));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule